// File: doc/BRIEF.md
# Both-Edge Capture Register

This block behaves as a register that takes a new value on every clock transition, rising and falling, while it is built only from ordinary single-edge flops and exclusive-OR logic. It is meant for targets whose cell library or fabric has no flop that fires on both edges and no double-rate capture cell. A design can then move data at twice the clock rate without a second, faster clock.

Inside, one bank of flops fires on the rising edge and a second bank fires on the falling edge. Each bank stores the incoming word XORed with the other bank's present contents. The visible output is the XOR of the two banks. After any edge the output therefore equals the word that was present at that edge. Only one bank changes per edge, so the output moves once per edge and does not pulse in between. The cost is the XOR on the way into each bank and the XOR on the way out. Setup time and clock-to-output delay are both longer than for a plain flop. Every bit of the word has its own copy of the structure and does not depend on the other bits.

Top module: `dfe_top`

## Requirements
- R1: While `rst_n` is low, `dout` is all zeros, whatever `din` and `clk` do. This also holds when reset is applied in the middle of operation.
- R2: After each rising edge of `clk` with reset released, `dout` equals the value `din` had at that rising edge.
- R3: After each falling edge of `clk` with reset released, `dout` equals the value `din` had at that falling edge.
- R4: A change on `din` between two clock edges has no effect on `dout` until the next edge of either polarity.
- R5: Each bit of `dout` depends only on the same bit position of `din`. A word with a single set bit at position k produces a word with only bit k set.
- R6: The first edge after reset is released is captured correctly, whether it is rising or falling. The clock's high and low phases need not be equal.
- R7: When the same word is presented at consecutive edges, `dout` keeps that word without change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both transitions capture data |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | WIDTH | Data word sampled on every edge |
| dout | output | WIDTH | Most recently captured data word |

## Verification
The clock runs with 30 % high time, so a rising-edge capture and a falling-edge capture are separated by unequal intervals. A table of words is replayed with a chosen edge polarity for each word.

- Mixing alternating and repeated polarities separates a correct rising capture (R2) from a correct falling capture (R3). It also shows whether a word survives a second edge unchanged (R7).
- Walking-one and walking-zero words expose any cross-coupling between bit lanes (R5).
- Moving `din` in the middle of a phase shows whether the output leaks between edges (R4).
- Releasing reset before either polarity of edge, and applying reset in mid-run, checks the clear and the first capture (R1, R6).

// File: rtl/dfe_pkg.sv
package dfe_pkg;

    // Selects which clock transition a storage bank responds to.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    localparam int unsigned DFE_DEFAULT_WIDTH = 8;

endpackage

// File: rtl/dfe_bank.sv
// One storage bank: holds (din XOR partner) on its selected clock edge.
module dfe_bank
    import dfe_pkg::*;
#(
    parameter int unsigned WIDTH = DFE_DEFAULT_WIDTH,
    parameter edge_sel_e   EDGE  = EDGE_RISE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] partner_q,
    output logic [WIDTH-1:0] bank_q
);

    typedef struct packed {
        logic [WIDTH-1:0] code;
    } bank_t;

    bank_t bank_d;
    bank_t bank_r;

    // Next value: the incoming word encoded against the other bank.
    always_comb begin
        bank_d = bank_r;
        for (int i = 0; i < int'(WIDTH); i++) begin
            bank_d.code[i] = din[i] ^ partner_q[i];
        end
    end

    generate
        if (EDGE == EDGE_RISE) begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bank_r <= '0;
                end else begin
                    bank_r <= bank_d;
                end
            end
        end else begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bank_r <= '0;
                end else begin
                    bank_r <= bank_d;
                end
            end
        end
    endgenerate

    assign bank_q = bank_r.code;

endmodule

// File: rtl/dfe_merge.sv
// Output decode: per-lane XOR of the two banks.
module dfe_merge #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] rise_q,
    input  logic [WIDTH-1:0] fall_q,
    output logic [WIDTH-1:0] dout
);

    genvar g;
    generate
        for (g = 0; g < int'(WIDTH); g++) begin : g_lane
            assign dout[g] = rise_q[g] ^ fall_q[g];
        end
    endgenerate

endmodule

// File: rtl/dfe_top.sv
module dfe_top
    import dfe_pkg::*;
#(
    parameter int unsigned WIDTH = DFE_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] rise_q;
    logic [WIDTH-1:0] fall_q;

    dfe_bank #(.WIDTH(WIDTH), .EDGE(EDGE_RISE)) u_rise (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .partner_q (fall_q),
        .bank_q    (rise_q)
    );

    dfe_bank #(.WIDTH(WIDTH), .EDGE(EDGE_FALL)) u_fall (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .partner_q (rise_q),
        .bank_q    (fall_q)
    );

    dfe_merge #(.WIDTH(WIDTH)) u_merge (
        .rise_q (rise_q),
        .fall_q (fall_q),
        .dout   (dout)
    );

endmodule

// File: rtl/dfe_top_chk.sv
module dfe_top_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] rise_din_q;
    logic [WIDTH-1:0] fall_din_q;
    logic             rise_seen_q;
    logic             fall_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_din_q  <= '0;
            rise_seen_q <= 1'b0;
        end else begin
            rise_din_q  <= din;
            rise_seen_q <= 1'b1;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_din_q  <= '0;
            fall_seen_q <= 1'b0;
        end else begin
            fall_din_q  <= din;
            fall_seen_q <= 1'b1;
        end
    end

    // R2: value held through the high phase is the word seen at the rising edge
    a_r2_rise_capture: assert property (@(negedge clk) disable iff (!rst_n)
        rise_seen_q |-> dout == rise_din_q);

    // R3: value held through the low phase is the word seen at the falling edge
    a_r3_fall_capture: assert property (@(posedge clk) disable iff (!rst_n)
        fall_seen_q |-> dout == fall_din_q);

    // R1: output clear while reset is held, checked on both edges
    a_r1_clear_rise: assert property (@(posedge clk)
        !rst_n |-> dout == '0);

    a_r1_clear_fall: assert property (@(negedge clk)
        !rst_n |-> dout == '0);

endmodule

bind dfe_top dfe_top_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .dout  (dout)
);

// File: tb/sim_dfe_top.sv
`timescale 1ns/1ps
module sim_dfe_top;

    localparam int unsigned W = 8;

    logic         clk;
    logic         rst_n;
    logic [W-1:0] din;
    logic [W-1:0] dout;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    dfe_top #(.WIDTH(W)) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .dout  (dout)
    );

    // 100 MHz, 3 ns high / 7 ns low
    initial begin
        clk = 1'b0;
        forever begin
            #7 clk = 1'b1;
            #3 clk = 1'b0;
        end
    end

    // {edge (1 = falling), data}; expected output is the data itself
    localparam logic [W:0] VEC [20] = '{
        {1'b0, 8'hA5}, {1'b1, 8'h5A}, {1'b0, 8'hFF}, {1'b1, 8'h00},
        {1'b0, 8'h3C}, {1'b0, 8'h3C}, {1'b1, 8'hC3}, {1'b1, 8'hC3},
        {1'b0, 8'h01}, {1'b1, 8'h80}, {1'b1, 8'h7E}, {1'b0, 8'h81},
        {1'b0, 8'h00}, {1'b1, 8'hFF}, {1'b0, 8'hFF}, {1'b1, 8'h12},
        {1'b0, 8'h34}, {1'b1, 8'h56}, {1'b0, 8'h78}, {1'b1, 8'h9A}
    };

    task automatic check(input logic [W-1:0] exp, input string req);
        n_cmp++;
        if (dout !== exp) begin
            n_bad++;
            $display("FAIL %s: dout=%h expected=%h at %0t", req, dout, exp, $time);
        end
    endtask

    task automatic hit(input logic fall, input logic [W-1:0] val, input string req);
        din = val;
        if (fall) @(negedge clk); else @(posedge clk);
        #1;
        check(val, req);
    endtask

    initial begin
        rst_n = 1'b0;
        din   = 8'hFF;
        // R1: clear while reset held, with data moving across edges
        @(posedge clk); #1; check('0, "R1");
        din = 8'h5A;
        @(negedge clk); #1; check('0, "R1");
        // R6: release in the low phase so the first edge is rising
        #2 rst_n = 1'b1;
        hit(1'b0, 8'hC7, "R6");
        hit(1'b1, 8'h2B, "R3");
        // table walk: R2 rising, R3 falling, R7 repeats
        for (int i = 0; i < 20; i++) begin
            hit(VEC[i][W], VEC[i][W-1:0], VEC[i][W] ? "R3" : "R2");
        end
        // R7: same word at several consecutive edges
        for (int i = 0; i < 4; i++) hit(i[0], 8'h66, "R7");
        // R5: walking one and walking zero, alternating polarity
        for (int k = 0; k < int'(W); k++) begin
            hit(k[0], 8'(1 << k), "R5");
            hit(!k[0], ~8'(1 << k), "R5");
        end
        // R4: change din mid-phase, output must hold until the edge
        hit(1'b0, 8'h11, "R2");
        din = 8'hEE; #1; check(8'h11, "R4");
        @(negedge clk); #1; check(8'hEE, "R3");
        din = 8'h44; #3; check(8'hEE, "R4");
        din = 8'h99; #2; check(8'hEE, "R4");
        @(posedge clk); #1; check(8'h99, "R2");
        // random data on both edges
        for (int i = 0; i < 200; i++) begin
            hit(i[0], 8'($urandom), i[0] ? "R3" : "R2");
        end
        // R1: asynchronous reset mid-run, in the low phase
        @(negedge clk); #2; rst_n = 1'b0; #1; check('0, "R1");
        din = 8'hAB;
        @(posedge clk); #1; check('0, "R1");
        // R6: release in the high phase so the first edge is falling
        rst_n = 1'b1;
        hit(1'b1, 8'hAB, "R6");
        hit(1'b0, 8'hCD, "R2");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            #(200000 * 10);
        join_any
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected done=1");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule